// File: doc/BRIEF.md
# Clock Synthesizer Control and Lock Tracker

This block is the register-side front end of a frequency synthesizer. Software reaches it through a small word-addressed read/write bus. Through that bus it programs the pre-divider, loop multiplier and post-divider factors, a loop-bandwidth trim, and three control bits: enable, relock and bypass. The block drives these settings straight to the analog loop. Each factor is stored as its value minus one, so a field of 0 means divide or multiply by 1. The programmed output frequency is the reference frequency divided by the pre-divider, multiplied by the loop multiplier and divided by the post-divider. The block runs entirely on the reference clock.

Lock acquisition is modelled with a down-counter. The wait is `LOCK_SCALE` times the effective pre-divider, in reference cycles, and `LOCK_SCALE` defaults to 500. A four-state machine tracks the loop. In OFF the loop is disabled. The transition *start* goes from OFF to ACQUIRE when enable rises. In ACQUIRE the counter runs. The transition *settle* goes from ACQUIRE to LOCKED when the counter reaches zero. LOCKED reports lock. The transition *retune* goes from ACQUIRE or LOCKED to STALE when the dividers change under a running loop. The transition *relock* goes from ACQUIRE, LOCKED or STALE to ACQUIRE when a relock request arrives while the loop is enabled, and it reloads the counter. The transition *shutdown* goes from any enabled state to OFF when enable is cleared. Software polls the lock flag until it reads 1.

The parameter `GATED_RECONFIG` picks the retune rule. When it is 0, divider writes land at any time, and a running loop then waits in STALE for a relock request. When it is 1, divider writes are accepted only in a write that also leaves enable clear. Bypass steers the output select to the reference and forces the lock flag to 1.

Top module: `pll_ctl_top`

## Requirements
- R1: After reset every stored field, the enable and bypass bits, the relock pulse and the lock flag are 0, and both registers read 0.
- R2: The control word at byte offset 0x0 holds enable in bit 0, the pre-divider in bits 7:2, the multiplier in bits 20:8, the post-divider in bits 24:21, bypass in bit 30 and the read-only lock flag in bit 31. The trim word at offset 0x4 holds the bandwidth trim in bits 14:3. The stored field values (value minus one) appear unchanged on the factor outputs.
- R3: Writing 1 to control bit 1 gives a one-cycle pulse on `pll_rst` in the cycle after the write. Bit 1 always reads 0.
- R4: When enable goes from 0 to 1, the lock flag reads 0 and rises exactly `LOCK_SCALE*(pre-divider field + 1)` cycles after the write edge.
- R5: A relock request while the loop is enabled clears the lock flag in the next cycle and restarts the full lock wait.
- R6: Clearing enable clears the lock flag in the next cycle (bypass clear).
- R7: With `GATED_RECONFIG=0`, a divider change under a running loop is applied at once and clears the lock flag. The flag stays 0 until a relock request has been made and the lock wait has elapsed.
- R8: With `GATED_RECONFIG=1`, divider fields in a write that leaves enable set are ignored. Divider fields in a write that clears enable are applied.
- R9: While bypass is set, `clk_sel_ref` is 1 and the lock flag reads 1.
- R10: Unused bits read 0 and ignore writes. Writing all ones reads back 0xC1FFFFFD at 0x0 and 0x00007FF8 at 0x4. Other or misaligned addresses read 0 and ignore writes.
- R11: A read request returns `rd_valid` with its data in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pll_en | output | 1 | Loop enable |
| pll_rst | output | 1 | One-cycle relock pulse |
| ref_div | output | 6 | Pre-divider field (value minus one) |
| fb_mul | output | 13 | Loop multiplier field (value minus one) |
| out_div | output | 4 | Post-divider field (value minus one) |
| bw_adj | output | 12 | Bandwidth trim field |
| clk_sel_ref | output | 1 | Output select follows reference (bypass) |
| locked | output | 1 | Lock flag |

## Verification
Some rules are checked on every cycle by the assertions. These are: the relock pulse has a matching write behind it, and bit 1 of read data is always 0. Bypass implies lock, a disabled loop outside bypass is unlocked, and a lock rise needs the loop to have been enabled. In gated mode the factors hold steady while the loop stays enabled. The read latency and the reads from unmapped addresses are also checked. Some behaviour only the bench scenarios can show. These are the exact lock-wait length for different pre-divider values, the STALE hold until relock, and the difference between the two retune rules on the same write sequence. The all-ones readback masks are also scenario-only.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
    localparam int WORD_W   = 32;
    localparam int EN_BIT   = 0;
    localparam int RST_BIT  = 1;
    localparam int NR_LSB   = 2;
    localparam int NR_W     = 6;
    localparam int NF_LSB   = 8;
    localparam int NF_W     = 13;
    localparam int OD_LSB   = 21;
    localparam int OD_W     = 4;
    localparam int BYP_BIT  = 30;
    localparam int LCK_BIT  = 31;
    localparam int BW_LSB   = 3;
    localparam int BW_W     = 12;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ACQUIRE,
        ST_LOCKED,
        ST_STALE
    } lock_state_e;

    typedef struct packed {
        logic [OD_W-1:0] od;
        logic [NF_W-1:0] nf;
        logic [NR_W-1:0] nr;
    } div_set_t;
endpackage

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
    import pll_ctl_pkg::*;
#(
    parameter int ADDR_W         = 4,
    parameter bit GATED_RECONFIG = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    output logic                en_q,
    output logic                en_d,
    output logic                byp_q,
    output div_set_t            div_q,
    output div_set_t            div_d,
    output logic [BW_W-1:0]     bw_q,
    output logic                rst_pulse_q,
    output logic                evt_en_rise,
    output logic                evt_en_fall,
    output logic                evt_relock,
    output logic                evt_retune
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;
    logic             wr_ctrl;
    logic             wr_bw;
    logic             div_ok;
    div_set_t         div_wr;
    logic             unused_wbits;

    assign word_idx = req_addr[ADDR_W-1:2];
    assign aligned  = (req_addr[1:0] == 2'b00);
    assign wr_ctrl  = req_valid && req_write && aligned && (word_idx == IDX_W'(0));
    assign wr_bw    = req_valid && req_write && aligned && (word_idx == IDX_W'(1));

    assign div_wr.od = req_wdata[OD_LSB +: OD_W];
    assign div_wr.nf = req_wdata[NF_LSB +: NF_W];
    assign div_wr.nr = req_wdata[NR_LSB +: NR_W];

    // Retune rule: gated variant accepts factors only when the write leaves enable clear.
    generate
        if (GATED_RECONFIG) begin : g_gated
            assign div_ok = !req_wdata[EN_BIT];
        end else begin : g_live
            assign div_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        en_d        = wr_ctrl ? req_wdata[EN_BIT] : en_q;
        div_d       = (wr_ctrl && div_ok) ? div_wr : div_q;
        evt_en_rise = wr_ctrl && req_wdata[EN_BIT] && !en_q;
        evt_en_fall = wr_ctrl && !req_wdata[EN_BIT] && en_q;
        evt_relock  = wr_ctrl && req_wdata[RST_BIT];
        evt_retune  = wr_ctrl && en_q && en_d && (div_d != div_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            byp_q       <= 1'b0;
            div_q       <= '0;
            bw_q        <= '0;
            rst_pulse_q <= 1'b0;
        end else begin
            en_q        <= en_d;
            div_q       <= div_d;
            rst_pulse_q <= evt_relock;
            if (wr_ctrl) byp_q <= req_wdata[BYP_BIT];
            if (wr_bw)   bw_q  <= req_wdata[BW_LSB +: BW_W];
        end
    end

    assign unused_wbits = ^{req_wdata[29:25], req_wdata[31]};
endmodule

// File: rtl/pll_ctl_lock_fsm.sv
module pll_ctl_lock_fsm
    import pll_ctl_pkg::*;
#(
    parameter int LOCK_SCALE = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_en_rise,
    input  logic            evt_en_fall,
    input  logic            evt_relock,
    input  logic            evt_retune,
    input  logic            en_d,
    input  logic [NR_W-1:0] nr_next,
    input  logic            byp,
    output logic            locked
);
    localparam int CNT_W = $clog2(LOCK_SCALE * (2 ** NR_W) + 1);
    localparam logic [CNT_W-1:0] SCALE = CNT_W'(LOCK_SCALE);

    lock_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             go_acq;

    assign go_acq   = en_d && (evt_en_rise || evt_relock);
    assign load_val = SCALE * (CNT_W'(nr_next) + CNT_W'(1)) - CNT_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Transitions: start, settle, retune, relock, shutdown
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (go_acq) state_d = ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
                if (evt_en_fall)          state_d = ST_OFF;
                else if (go_acq)          state_d = ST_ACQUIRE;
                else if (evt_retune)      state_d = ST_STALE;
                else if (cnt_q == '0)     state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (evt_en_fall)          state_d = ST_OFF;
                else if (go_acq)          state_d = ST_ACQUIRE;
                else if (evt_retune)      state_d = ST_STALE;
            end
            ST_STALE: begin
                if (evt_en_fall)          state_d = ST_OFF;
                else if (go_acq)          state_d = ST_ACQUIRE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Lock-wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (go_acq) begin
            cnt_q <= load_val;
        end else if (state_q == ST_ACQUIRE && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        locked = byp || (state_q == ST_LOCKED);
    end
endmodule

// File: rtl/pll_ctl_rdport.sv
module pll_ctl_rdport
    import pll_ctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              en_q,
    input  logic              byp_q,
    input  div_set_t          div_q,
    input  logic [BW_W-1:0]   bw_q,
    input  logic              locked,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] ctrl_word;
    logic [WORD_W-1:0] bw_word;
    logic [WORD_W-1:0] sel_word;

    assign word_idx = req_addr[ADDR_W-1:2];

    always_comb begin
        ctrl_word                       = '0;
        ctrl_word[EN_BIT]               = en_q;
        ctrl_word[NR_LSB +: NR_W]       = div_q.nr;
        ctrl_word[NF_LSB +: NF_W]       = div_q.nf;
        ctrl_word[OD_LSB +: OD_W]       = div_q.od;
        ctrl_word[BYP_BIT]              = byp_q;
        ctrl_word[LCK_BIT]              = locked;
        bw_word                         = '0;
        bw_word[BW_LSB +: BW_W]         = bw_q;
        sel_word                        = '0;
        if (req_addr[1:0] == 2'b00) begin
            if (word_idx == IDX_W'(0))      sel_word = ctrl_word;
            else if (word_idx == IDX_W'(1)) sel_word = bw_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rd_data <= sel_word;
        end
    end
endmodule

// File: rtl/pll_ctl_top.sv
module pll_ctl_top
    import pll_ctl_pkg::*;
#(
    parameter int ADDR_W         = 4,
    parameter int LOCK_SCALE     = 500,
    parameter bit GATED_RECONFIG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              pll_en,
    output logic              pll_rst,
    output logic [5:0]        ref_div,
    output logic [12:0]       fb_mul,
    output logic [3:0]        out_div,
    output logic [11:0]       bw_adj,
    output logic              clk_sel_ref,
    output logic              locked
);
    logic      en_q, en_d, byp_q, rst_pulse_q;
    logic      evt_en_rise, evt_en_fall, evt_relock, evt_retune;
    div_set_t  div_q, div_d;
    logic [BW_W-1:0] bw_q;

    pll_ctl_regs #(
        .ADDR_W         (ADDR_W),
        .GATED_RECONFIG (GATED_RECONFIG)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .en_q        (en_q),
        .en_d        (en_d),
        .byp_q       (byp_q),
        .div_q       (div_q),
        .div_d       (div_d),
        .bw_q        (bw_q),
        .rst_pulse_q (rst_pulse_q),
        .evt_en_rise (evt_en_rise),
        .evt_en_fall (evt_en_fall),
        .evt_relock  (evt_relock),
        .evt_retune  (evt_retune)
    );

    pll_ctl_lock_fsm #(
        .LOCK_SCALE (LOCK_SCALE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_en_rise (evt_en_rise),
        .evt_en_fall (evt_en_fall),
        .evt_relock  (evt_relock),
        .evt_retune  (evt_retune),
        .en_d        (en_d),
        .nr_next     (div_d.nr),
        .byp         (byp_q),
        .locked      (locked)
    );

    pll_ctl_rdport #(
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .en_q      (en_q),
        .byp_q     (byp_q),
        .div_q     (div_q),
        .bw_q      (bw_q),
        .locked    (locked),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign pll_en      = en_q;
    assign pll_rst     = rst_pulse_q;
    assign ref_div     = div_q.nr;
    assign fb_mul      = div_q.nf;
    assign out_div     = div_q.od;
    assign bw_adj      = bw_q;
    assign clk_sel_ref = byp_q;
endmodule

// File: rtl/pll_ctl_chk.sv
module pll_ctl_chk #(
    parameter int ADDR_W         = 4,
    parameter bit GATED_RECONFIG = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-3:0] word_idx,
    input logic              wr_rst_bit,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              pll_en,
    input logic              pll_rst,
    input logic [5:0]        ref_div,
    input logic [12:0]       fb_mul,
    input logic [3:0]        out_div,
    input logic              clk_sel_ref,
    input logic              locked
);
    // R3
    relock_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> $past(req_valid && req_write && word_idx == '0 && wr_rst_bit));

    // R3
    relock_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !rd_data[1]);

    // R4
    lock_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(locked) && !clk_sel_ref) |-> $past(pll_en));

    // R6
    disabled_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_en && !clk_sel_ref) |-> !locked);

    // R8
    gated_factor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (GATED_RECONFIG && pll_en && $past(pll_en)) |-> $stable({ref_div, fb_mul, out_div}));

    // R9
    bypass_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_ref |-> locked);

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && word_idx > 1) |=> (rd_data == '0));

    // R11
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);
endmodule

bind pll_ctl_top pll_ctl_chk #(
    .ADDR_W         (ADDR_W),
    .GATED_RECONFIG (GATED_RECONFIG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .word_idx    (req_addr[ADDR_W-1:2]),
    .wr_rst_bit  (req_wdata[1]),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .pll_en      (pll_en),
    .pll_rst     (pll_rst),
    .ref_div     (ref_div),
    .fb_mul      (fb_mul),
    .out_div     (out_div),
    .clk_sel_ref (clk_sel_ref),
    .locked      (locked)
);

// File: tb/pll_ctl_top_test.sv
module pll_ctl_top_test;
    localparam int AW = 4;
    localparam int LS = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;

    logic rd_valid, pll_en, pll_rst, clk_sel_ref, locked;
    logic [31:0] rd_data;
    logic [5:0] ref_div;
    logic [12:0] fb_mul;
    logic [3:0] out_div;
    logic [11:0] bw_adj;

    logic g_rd_valid, g_pll_en, g_pll_rst, g_clk_sel_ref, g_locked;
    logic [31:0] g_rd_data;
    logic [5:0] g_ref_div;
    logic [12:0] g_fb_mul;
    logic [3:0] g_out_div;
    logic [11:0] g_bw_adj;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] data;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    pll_ctl_top #(.ADDR_W(AW), .LOCK_SCALE(LS), .GATED_RECONFIG(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .pll_en(pll_en), .pll_rst(pll_rst), .ref_div(ref_div), .fb_mul(fb_mul),
        .out_div(out_div), .bw_adj(bw_adj), .clk_sel_ref(clk_sel_ref), .locked(locked));

    pll_ctl_top #(.ADDR_W(AW), .LOCK_SCALE(LS), .GATED_RECONFIG(1'b1)) uut_gated (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(g_rd_valid), .rd_data(g_rd_data),
        .pll_en(g_pll_en), .pll_rst(g_pll_rst), .ref_div(g_ref_div), .fb_mul(g_fb_mul),
        .out_div(g_out_div), .bw_adj(g_bw_adj), .clk_sel_ref(g_clk_sel_ref), .locked(g_locked));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        exp_t item;
        item.tag = tag; item.data = exp;
        exp_q.push_back(item);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [31:0] ctl(input int nr, input int nf, input int od);
        return (32'(nr) << 2) | (32'(nf) << 8) | (32'(od) << 21);
    endfunction

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read response", 32'd1, 32'd0);
            end else begin
                exp_t item;
                item = exp_q.pop_front();
                check(item.tag, rd_data, item.data);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v1, v2;
        v1 = ctl(3, 49, 1);
        v2 = ctl(3, 30, 1);

        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R1 reset state
        check("R1 pll_en", 32'(pll_en), 0);
        check("R1 locked", 32'(locked), 0);
        check("R1 fb_mul", 32'(fb_mul), 0);
        check("R1 pll_rst", 32'(pll_rst), 0);
        rd(4'h0, 32'h0, "R1 ctrl read");
        rd(4'h4, 32'h0, "R1 trim read");

        // R2 field placement
        wr(4'h0, v1);
        check("R2 ref_div", 32'(ref_div), 3);
        check("R2 fb_mul", 32'(fb_mul), 49);
        check("R2 out_div", 32'(out_div), 1);
        check("R8 gated accepts with enable clear", 32'(g_fb_mul), 49);
        rd(4'h0, v1, "R2 ctrl readback");
        wr(4'h4, 32'h5A5 << 3);
        check("R2 bw_adj", 32'(bw_adj), 32'h5A5);
        rd(4'h4, 32'h5A5 << 3, "R2 trim readback");

        // R4 lock wait = LS*(3+1) = 80 cycles
        wr(4'h0, v1 | 32'h1);
        check("R4 locked right after enable", 32'(locked), 0);
        cycles(LS * 4 - 1);
        check("R4 locked one cycle early", 32'(locked), 0);
        cycles(1);
        check("R4 locked at lock time", 32'(locked), 1);
        rd(4'h0, v1 | 32'h1 | 32'h8000_0000, "R4 lock bit read");

        // R3 and R5 relock
        wr(4'h0, v1 | 32'h3);
        check("R3 pll_rst pulse", 32'(pll_rst), 1);
        check("R5 lock dropped", 32'(locked), 0);
        cycles(1);
        check("R3 pll_rst self-clear", 32'(pll_rst), 0);
        cycles(LS * 4 - 2);
        check("R5 still acquiring", 32'(locked), 0);
        cycles(1);
        check("R5 relocked", 32'(locked), 1);
        rd(4'h0, v1 | 32'h1 | 32'h8000_0000, "R3 reset bit reads 0");

        // R7 / R8 retune under running loop
        wr(4'h0, v2 | 32'h1);
        check("R7 factor applied live", 32'(fb_mul), 30);
        check("R7 lock dropped", 32'(locked), 0);
        check("R8 gated factor ignored", 32'(g_fb_mul), 49);
        check("R8 gated lock kept", 32'(g_locked), 1);
        cycles(200);
        check("R7 stale until relock", 32'(locked), 0);
        wr(4'h0, v2 | 32'h3);
        cycles(LS * 4);
        check("R7 relocked after request", 32'(locked), 1);

        // R6 / R8 disable with new factors
        wr(4'h0, v2);
        check("R6 lock cleared", 32'(locked), 0);
        check("R6 enable cleared", 32'(pll_en), 0);
        check("R8 gated applies with enable clear", 32'(g_fb_mul), 30);
        check("R6 gated lock cleared", 32'(g_locked), 0);

        // R9 bypass
        wr(4'h0, 32'h4000_0000);
        check("R9 clk_sel_ref", 32'(clk_sel_ref), 1);
        check("R9 lock forced", 32'(locked), 1);
        rd(4'h0, 32'hC000_0000, "R9 bypass readback");
        wr(4'h0, 32'h0);
        check("R9 lock released", 32'(locked), 0);

        // R10 unused bits and addresses
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, 32'hC1FF_FFFD, "R10 ctrl mask");
        wr(4'h0, 32'h0);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'h2, 32'hFFFF_FFFF);
        rd(4'h8, 32'h0, "R10 unmapped read");
        rd(4'h0, 32'h0, "R10 unmapped write ignored");
        check("R10 misaligned write ignored", 32'(pll_en), 0);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, 32'h0000_7FF8, "R10 trim mask");
        check("R10 bw_adj all ones", 32'(bw_adj), 32'hFFF);

        // R4 boundary: pre-divider field 0 -> LS cycles
        wr(4'h0, 32'h1);
        cycles(LS - 1);
        check("R4 min divider early", 32'(locked), 0);
        cycles(1);
        check("R4 min divider lock", 32'(locked), 1);

        cycles(3);
        check("R11 all reads answered", 32'(exp_q.size()), 0);
        done = 1'b1;
        finish_run();
    end
endmodule